// File: doc/BRIEF.md
# Warp Memory Transaction Coalescer

This block takes one memory request issued by a 32-lane warp and splits it into the smallest set of memory transactions. Each lane supplies a byte address and an active flag. The whole request carries one access size of 4, 8 or 16 bytes. The size sets how the lanes are split into service groups: the full warp for 4 bytes, halves of 16 lanes for 8 bytes, and quarters of 8 lanes for 16 bytes. Memory is cut into aligned 128-byte segments. Within each service group, every distinct segment touched by an active lane costs one transaction.

Each transaction gives the segment base address and a 32-bit mask of the lanes it serves. Transactions leave through a valid/ready handshake at one per cycle, in ascending order of the lowest lane that touches each segment. A one-cycle completion pulse marks the end of each request. The block takes a new request only after the previous one has fully drained.

Top module: `warp_coalescer`

## Requirements
- R1: Each transaction's `txn_base` is a multiple of 128, and every lane set in `txn_mask` addresses a byte in `[txn_base, txn_base+127]`.
- R2: `req_size` selects the service group: 0 means 4-byte accesses across all 32 lanes, 1 means 8-byte accesses in 16-lane halves (lanes 0-15 and 16-31), and 2 or 3 means 16-byte accesses in 8-lane quarters. Lanes from different groups never share a transaction.
- R3: Exactly one transaction is issued per distinct segment per group. When 32 active lanes read consecutive 4-byte words of one aligned segment, one transaction with mask 0xFFFFFFFF results.
- R4: With 32 active 4-byte lanes at a 36-byte stride (a span of 288 words) starting 100 bytes into a segment, exactly 10 transactions result.
- R5: Inactive lanes appear in no mask and add no segment. A request with no active lanes issues no transaction.
- R6: Transactions come out in ascending order of the lowest lane of each, one per cycle while `txn_ready` is high. Each mask holds every remaining lane of that group whose address falls in that segment.
- R7: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_base` and `txn_mask` hold steady.
- R8: `done` is high for exactly one cycle. That cycle is the one after the last transaction is accepted, or the one after acceptance for an empty request. `done` is never high together with `txn_valid`.
- R9: `req_ready` is low from the cycle after a request is accepted until `done` has been shown. A `req_valid` during that time is ignored.
- R10: The first transaction (or `done`, for an empty request) is presented in the cycle right after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_addr | input | 1024 | Byte address per lane, lane n in bits [32n+31:32n] |
| req_active | input | 32 | Active flag per lane |
| req_size | input | 2 | Access size code (0: 4 B, 1: 8 B, 2/3: 16 B) |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Consumer accepts the transaction |
| txn_base | output | 32 | Aligned 128-byte segment base address |
| txn_mask | output | 32 | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse after the request has drained |

## Verification
A request is accepted on the rising edge where `req_valid` and `req_ready` are both high. Its first transaction, or `done` for an empty request, is due in the very next cycle. Each later transaction is due in the cycle after the edge where the previous one was accepted, and `done` is due one cycle after the final acceptance. The bench drives inputs and samples outputs on falling edges only. It compares each sample against a list of segments and masks computed in the bench, and advances through that list only on cycles where it drove `txn_ready` high. This keeps stalled cycles checked against the same expected transaction.

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES  = 32,
  parameter int AW     = 32,
  parameter int SEG_LG = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES-1:0]    req_active,
  input  logic [1:0]          req_size,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [AW-1:0]       txn_base,
  output logic [LANES-1:0]    txn_mask,
  output logic                done
);
  localparam int LG  = $clog2(LANES);
  localparam int SW  = AW - SEG_LG;
  localparam int GSW = $clog2(LG + 1);

  logic             busy;
  logic [LANES-1:0] pend;
  logic [1:0]       size_q;
  logic [AW-1:0]    addr_q [LANES];

  logic [GSW-1:0]   gshift;
  logic [LG-1:0]    first;
  logic [SW-1:0]    seg_first;
  logic [LANES-1:0] sel;

  assign gshift = (size_q == 2'd0) ? GSW'(LG) :
                  (size_q == 2'd1) ? GSW'(LG - 1) : GSW'(LG - 2);

  always_comb begin
    first = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (pend[i]) first = LG'(i);
  end

  assign seg_first = addr_q[first][AW-1:SEG_LG];

  always_comb begin
    for (int m = 0; m < LANES; m++)
      sel[m] = pend[m] && (addr_q[m][AW-1:SEG_LG] == seg_first) &&
               ((LG'(m) >> gshift) == (first >> gshift));
  end

  assign req_ready = !busy;
  assign txn_valid = busy && |pend;
  assign done      = busy && !(|pend);
  assign txn_base  = {seg_first, {SEG_LG{1'b0}}};
  assign txn_mask  = sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pend   <= '0;
      size_q <= '0;
    end else if (!busy) begin
      if (req_valid) begin
        busy   <= 1'b1;
        pend   <= req_active;
        size_q <= req_size;
      end
    end else if (!(|pend)) begin
      busy <= 1'b0;
    end else if (txn_ready) begin
      pend <= pend & ~sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!busy && req_valid)
      for (int i = 0; i < LANES; i++) addr_q[i] <= req_addr[i*AW +: AW];
  end

  // R7: a stalled transaction stays put
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) && $stable(txn_mask));

  // R3, R6: an accepted transaction retires exactly its own lanes
  p_retire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_ready |=> pend == ($past(pend) & ~$past(txn_mask)));

  // R5: a mask never names a lane that is not pending
  p_mask_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_mask != '0 && (txn_mask & ~pend) == '0);

  // R8: done is a single-cycle pulse, exclusive with a transaction
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !txn_valid);

  p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && txn_valid));

  // R10: something is presented right after acceptance
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> (txn_valid || done) && !req_ready);

  // R9: no acceptance while draining
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> !req_ready);
endmodule

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1023:0] req_addr = '0;
  logic [31:0]   req_active = '0;
  logic [1:0]    req_size = '0;
  logic          txn_valid;
  logic          txn_ready = 1'b0;
  logic [31:0]   txn_base;
  logic [31:0]   txn_mask;
  logic          done;

  int tests = 0;
  int fails = 0;

  logic [31:0] a [32];
  logic [31:0] act;
  logic [31:0] eb [32];
  logic [31:0] em [32];
  int          ecnt;

  always #10 clk = ~clk;

  warp_coalescer u_warp_coalescer (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_active, .req_size,
    .txn_valid, .txn_ready, .txn_base, .txn_mask, .done
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act_v, input logic [63:0] exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic model(input logic [1:0] sz);
    int gs;
    logic [31:0] used;
    gs = (sz == 2'd0) ? 32 : (sz == 2'd1) ? 16 : 8;
    used = '0;
    ecnt = 0;
    for (int l = 0; l < 32; l++) begin
      if (act[l] && !used[l]) begin
        logic [31:0] m;
        m = '0;
        for (int k = l; k < 32; k++)
          if (act[k] && !used[k] && (k / gs) == (l / gs) && (a[k] >> 7) == (a[l] >> 7)) begin
            m[k] = 1'b1;
            used[k] = 1'b1;
          end
        eb[ecnt] = (a[l] >> 7) << 7;
        em[ecnt] = m;
        ecnt++;
      end
    end
  endtask

  task automatic run(input logic [1:0] sz, input bit stall, input bit junk, input int want, input string tag);
    int idx;
    bit fin;
    model(sz);
    if (want >= 0) check(ecnt == want, {tag, " model count"}, 64'(ecnt), 64'(want));
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready before request", 64'(req_ready), 64'd1);
    for (int i = 0; i < 32; i++) req_addr[i*32 +: 32] = a[i];
    req_active = act;
    req_size = sz;
    req_valid = 1'b1;
    @(negedge clk);
    if (junk) begin
      for (int i = 0; i < 32; i++) req_addr[i*32 +: 32] = 32'hFFFF0000 + 32'(i * 4);
      req_active = '1;
      req_size = 2'd0;
    end else begin
      req_valid = 1'b0;
    end
    idx = 0;
    fin = 0;
    for (int c = 0; c < 200 && !fin; c++) begin
      txn_ready = stall ? 1'($urandom % 2) : 1'b1;
      #1;
      if (idx < ecnt) begin
        check(txn_valid && !done, {tag, " R10 R6 valid"}, {62'd0, txn_valid, done}, 64'd2);
        check(txn_base == eb[idx], {tag, " R1 R2 base"}, 64'(txn_base), 64'(eb[idx]));
        check(txn_mask == em[idx], {tag, " R3 R5 mask"}, 64'(txn_mask), 64'(em[idx]));
        check(!req_ready, {tag, " R9 busy"}, 64'(req_ready), 64'd0);
        if (txn_ready) idx++;
      end else begin
        check(done && !txn_valid, {tag, " R8 done"}, {62'd0, txn_valid, done}, 64'd1);
        fin = 1;
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    check(fin, {tag, " R8 completion"}, 64'(fin), 64'd1);
    check(!done && !txn_valid && req_ready, {tag, " R8 R9 idle after done"},
          {61'd0, done, txn_valid, req_ready}, 64'd1);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !txn_valid && !done, "reset state", {61'd0, req_ready, txn_valid, done}, 64'd4);
    rst_n = 1'b1;

    // R3: one segment, 4-byte coalesced
    for (int i = 0; i < 32; i++) a[i] = 32'h1000 + 32'(i * 4);
    act = '1;
    run(2'd0, 0, 0, 1, "R3 coalesced");

    // R4: 36-byte stride from offset 100
    for (int i = 0; i < 32; i++) a[i] = 32'h2064 + 32'(i * 36);
    run(2'd0, 0, 0, 10, "R4 stride");

    // R2: 8-byte contiguous -> two halves
    for (int i = 0; i < 32; i++) a[i] = 32'h4000 + 32'(i * 8);
    run(2'd1, 0, 0, 2, "R2 half");
    // same addresses at 4-byte size still span two segments
    run(2'd0, 0, 0, 2, "R2 full");

    // R2: 16-byte contiguous -> four quarters, code 2 and 3
    for (int i = 0; i < 32; i++) a[i] = 32'h8000 + 32'(i * 16);
    run(2'd2, 0, 0, 4, "R2 quarter");
    run(2'd3, 1, 0, 4, "R2 code3");

    // R6: interleaved segments, order by lowest lane
    for (int i = 0; i < 32; i++) a[i] = 32'h300 + 32'((i % 3) * 128);
    run(2'd0, 1, 0, 3, "R6 interleave");
    run(2'd1, 0, 0, 6, "R6 interleave half");

    // R5: partial and empty activity
    for (int i = 0; i < 32; i++) a[i] = 32'(i * 128);
    act = 32'h8000_0101;
    run(2'd0, 0, 0, 3, "R5 partial");
    act = '0;
    run(2'd0, 0, 0, 0, "R5 empty");
    run(2'd2, 0, 1, 0, "R5 R9 empty junk");

    // R9: requests during drain are ignored
    for (int i = 0; i < 32; i++) a[i] = 32'h6000 + 32'(i * 64);
    act = 32'h0F0F_F0F0;
    run(2'd0, 1, 1, -1, "R9 junk");

    // R7, R1: random sweep with stalls
    for (int t = 0; t < 300; t++) begin
      for (int i = 0; i < 32; i++) a[i] = 32'h10000 + ($urandom % 1024);
      act = $urandom;
      run(2'($urandom % 4), 1, (t % 5) == 0, -1, "R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule